// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block is the interrupt response unit of a small 8-bit processor core. Six request flags come in: two external requests, two timer overflows, a serial flag and a second-timer flag. Each flag has an enable bit and a priority bit, and a global enable gates all of them. Once per machine cycle (one clock here) the block polls the flags that were registered at the end of the previous cycle. It then decides whether to force a hardware subroutine call to a fixed vector address. The core tells the block when the current cycle ends an instruction, when that instruction is a return-from-interrupt, and when it reads or writes the enable or priority registers. No denied request is remembered: every poll starts afresh.

The block is a two-state machine. In `POLL`, a poll that finds a grantable request takes the transition POLL→CALL and latches the winning source and its level. A poll that finds none takes POLL→POLL. In `CALL`, the block holds `call_req` high for exactly one cycle. During that cycle it presents the vector and pulses the flag-clear strobes allowed for that source, then takes CALL→POLL unconditionally. The in-service bit for the granted level is set at the end of the `CALL` cycle. The core reports a finished return with `reti_done`, which clears the highest set in-service bit.

Top module: `intr_vector_unit`

## Requirements
- R1: A flag that is high on the input at clock edge E1 is polled in the cycle after E1. If that poll grants, `call_req` is high for exactly one cycle, directly after the following edge E2, and never on two consecutive cycles.
- R2: A source is a candidate only when its flag, its bit in `src_en` and `glob_en` are all high.
- R3: No call is granted by a poll in a cycle where `instr_last` is low.
- R4: No call is granted by a poll in a cycle where `instr_reti` or `instr_ie_ip` is high.
- R5: A high-level candidate is granted only if in-service bit 1 is clear. A low-level candidate is granted only if both in-service bits are clear.
- R6: A high-level candidate (bit set in `src_hi_pri`) always beats a low-level one. Within a level the lowest flag bit wins. The bits are ordered 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2.
- R7: During the call cycle, `call_vector` equals 0x0003 + 8 × (winning bit index), giving 0x0003, 0x000B, 0x0013, 0x001B, 0x0023 and 0x002B. Outside the call cycle it is 0x0000.
- R8: `flag_clr` is nonzero only in the call cycle, and then only on the winner's bit. The block clears timer0 and timer1 always, ext0 only when `ext_edge[0]` is 1, ext1 only when `ext_edge[1]` is 1, and never serial or timer2.
- R9: After a call, `in_service` bit 1 (high level) or bit 0 (low level) is set. A `reti_done` pulse clears bit 1 if it is set, otherwise bit 0.
- R10: A request denied while its flag was high is not serviced once its flag has dropped, even after the blocking condition is gone.
- R11: After reset, `call_req`, `call_vector`, `flag_clr` and `in_service` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_flags | input | 6 | Request flags (bit order as in R6) |
| src_en | input | 6 | Per-source enable |
| src_hi_pri | input | 6 | Per-source level: 1 high, 0 low |
| glob_en | input | 1 | Global interrupt enable |
| ext_edge | input | 2 | External request mode: 1 transition-activated, 0 level |
| instr_last | input | 1 | Current cycle is the last of its instruction |
| instr_reti | input | 1 | Instruction in progress is a return-from-interrupt |
| instr_ie_ip | input | 1 | Instruction in progress accesses enable or priority register |
| reti_done | input | 1 | Return-from-interrupt completed this cycle |
| call_req | output | 1 | Forced call request, one cycle |
| call_vector | output | 16 | Vector address during the call cycle |
| flag_clr | output | 6 | Hardware flag-clear strobes |
| in_service | output | 2 | In-service bits: bit 1 high level, bit 0 low level |

## Verification
Each source is raised alone, to confirm its vector and its clear rule in both external modes. Sets of simultaneous flags, spread across both levels and within a single level, separate the level rule from the fixed bit order. The same single request is then repeated with each gating input removed in turn: global enable, source enable, instruction end, return, register access. This shows that each input blocks the call on its own. Directed sequences nest a high-level call inside a low one, hold an equal-level request against an active routine, and check a denied flag that drops before the block is lifted. Together these separate preemption from level blocking and from pending-latch behaviour.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
    localparam int NUM_SRC = 6;
    localparam int IDX_W   = $clog2(NUM_SRC);

    localparam int SRC_EXT0 = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_EXT1 = 2;
    localparam int SRC_TMR1 = 3;
    localparam int SRC_SER  = 4;
    localparam int SRC_TMR2 = 5;

    // sources the hardware always clears on vectoring
    localparam logic [NUM_SRC-1:0] ALWAYS_CLR =
        (NUM_SRC'(1) << SRC_TMR0) | (NUM_SRC'(1) << SRC_TMR1);

    typedef enum logic [0:0] {
        ST_POLL = 1'b0,
        ST_CALL = 1'b1
    } ivu_state_e;
endpackage

// File: rtl/ivu_sampler.sv
module ivu_sampler #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] flags_in,
    output logic [WIDTH-1:0] flags_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_in;
    end
endmodule

// File: rtl/ivu_arbiter.sv
module ivu_arbiter
    import ivu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               poll_en,
    input  logic [NUM_SRC-1:0] flags_q,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_hi_pri,
    input  logic               glob_en,
    input  logic               instr_last,
    input  logic               instr_reti,
    input  logic               instr_ie_ip,
    input  logic [1:0]         in_service,
    output logic               grant,
    output logic               grant_hi,
    output logic [IDX_W-1:0]   grant_idx
);
    logic [NUM_SRC-1:0] cand, hi_cand, lo_cand;
    logic [IDX_W-1:0]   hi_idx, lo_idx;
    logic               boundary_ok, hi_ok, lo_ok;

    assign cand    = flags_q & src_en & {NUM_SRC{glob_en}};
    assign hi_cand = cand & src_hi_pri;
    assign lo_cand = cand & ~src_hi_pri;

    // fixed order: lowest bit index wins within a level
    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (hi_cand[i]) hi_idx = IDX_W'(i);
            if (lo_cand[i]) lo_idx = IDX_W'(i);
        end
    end

    assign boundary_ok = instr_last && !instr_reti && !instr_ie_ip;
    assign hi_ok = (|hi_cand) && !in_service[1];
    assign lo_ok = (|lo_cand) && (in_service == 2'b00);

    always_comb begin
        grant     = 1'b0;
        grant_hi  = 1'b0;
        grant_idx = '0;
        if (poll_en && boundary_ok) begin
            if (hi_ok) begin
                grant     = 1'b1;
                grant_hi  = 1'b1;
                grant_idx = hi_idx;
            end else if (lo_ok) begin
                grant     = 1'b1;
                grant_idx = lo_idx;
            end
        end
    end

    assert_grant_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> instr_last);
    assert_grant_not_reti_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (!instr_reti && !instr_ie_ip));
    assert_grant_is_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (glob_en && flags_q[grant_idx] && src_en[grant_idx]));
    assert_level_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !grant_hi) |-> (in_service == 2'b00));
endmodule

// File: rtl/ivu_level_track.sv
module ivu_level_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_en,
    input  logic       set_hi,
    input  logic       clr_en,
    output logic [1:0] in_service
);
    logic [1:0] isv_q, isv_d;

    always_comb begin
        isv_d = isv_q;
        if (clr_en) begin
            if (isv_q[1]) isv_d[1] = 1'b0;
            else          isv_d[0] = 1'b0;
        end
        if (set_en) begin
            if (set_hi) isv_d[1] = 1'b1;
            else        isv_d[0] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isv_q <= 2'b00;
        else        isv_q <= isv_d;
    end

    assign in_service = isv_q;

    assert_set_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && set_hi) |=> isv_q[1]);
    assert_set_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !set_hi) |=> isv_q[0]);
    assert_clr_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en && isv_q[1]) |=> (!isv_q[1] && isv_q[0] == $past(isv_q[0])));
endmodule

// File: rtl/intr_vector_unit.sv
module intr_vector_unit
    import ivu_pkg::*;
#(
    parameter logic [15:0] VEC_FIRST = 16'h0003,
    parameter logic [15:0] VEC_STEP  = 16'h0008
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [5:0]   req_flags,
    input  logic [5:0]   src_en,
    input  logic [5:0]   src_hi_pri,
    input  logic         glob_en,
    input  logic [1:0]   ext_edge,
    input  logic         instr_last,
    input  logic         instr_reti,
    input  logic         instr_ie_ip,
    input  logic         reti_done,
    output logic         call_req,
    output logic [15:0]  call_vector,
    output logic [5:0]   flag_clr,
    output logic [1:0]   in_service
);
    ivu_state_e         state_q, state_d;
    logic [IDX_W-1:0]   sel_idx_q, sel_idx_d;
    logic               sel_hi_q, sel_hi_d;
    logic [NUM_SRC-1:0] flags_q;
    logic               grant, grant_hi;
    logic [IDX_W-1:0]   grant_idx;
    logic [NUM_SRC-1:0] clr_ok;

    ivu_sampler #(.WIDTH(NUM_SRC)) u_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags_in (req_flags),
        .flags_q  (flags_q)
    );

    ivu_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll_en     (state_q == ST_POLL),
        .flags_q     (flags_q),
        .src_en      (src_en),
        .src_hi_pri  (src_hi_pri),
        .glob_en     (glob_en),
        .instr_last  (instr_last),
        .instr_reti  (instr_reti),
        .instr_ie_ip (instr_ie_ip),
        .in_service  (in_service),
        .grant       (grant),
        .grant_hi    (grant_hi),
        .grant_idx   (grant_idx)
    );

    ivu_level_track u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (state_q == ST_CALL),
        .set_hi     (sel_hi_q),
        .clr_en     (reti_done),
        .in_service (in_service)
    );

    // next-state logic
    always_comb begin
        state_d   = state_q;
        sel_idx_d = sel_idx_q;
        sel_hi_d  = sel_hi_q;
        unique case (state_q)
            ST_POLL: begin
                if (grant) begin
                    state_d   = ST_CALL;
                    sel_idx_d = grant_idx;
                    sel_hi_d  = grant_hi;
                end
            end
            ST_CALL: state_d = ST_POLL;
            default: state_d = ST_POLL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_POLL;
            sel_idx_q <= '0;
            sel_hi_q  <= 1'b0;
        end else begin
            state_q   <= state_d;
            sel_idx_q <= sel_idx_d;
            sel_hi_q  <= sel_hi_d;
        end
    end

    // outputs
    always_comb begin
        clr_ok           = ALWAYS_CLR;
        clr_ok[SRC_EXT0] = ext_edge[0];
        clr_ok[SRC_EXT1] = ext_edge[1];
        call_req    = 1'b0;
        call_vector = 16'h0000;
        flag_clr    = '0;
        unique case (state_q)
            ST_POLL: ;
            ST_CALL: begin
                call_req    = 1'b1;
                call_vector = VEC_FIRST + VEC_STEP * 16'(sel_idx_q);
                flag_clr    = (NUM_SRC'(1) << sel_idx_q) & clr_ok;
            end
            default: ;
        endcase
    end

    assert_call_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |=> !call_req);
    assert_clr_in_call_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_clr) |-> call_req);
    assert_clr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr));
    assert_vector_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> (call_vector[2:0] == 3'd3 && call_vector < 16'h0030));
    assert_idle_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !call_req |-> (call_vector == 16'h0000));
endmodule

// File: tb/intr_vector_unit_tb_top.sv
module intr_vector_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  req_flags = '0, src_en = '0, src_hi_pri = '0;
    logic        glob_en = 1'b0;
    logic [1:0]  ext_edge = '0;
    logic        instr_last = 1'b0, instr_reti = 1'b0, instr_ie_ip = 1'b0;
    logic        reti_done = 1'b0;
    logic        call_req;
    logic [15:0] call_vector;
    logic [5:0]  flag_clr;
    logic [1:0]  in_service;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    intr_vector_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_flags(req_flags), .src_en(src_en),
        .src_hi_pri(src_hi_pri), .glob_en(glob_en), .ext_edge(ext_edge),
        .instr_last(instr_last), .instr_reti(instr_reti), .instr_ie_ip(instr_ie_ip),
        .reti_done(reti_done), .call_req(call_req), .call_vector(call_vector),
        .flag_clr(flag_clr), .in_service(in_service)
    );

    typedef struct packed {
        logic [5:0]  flags;
        logic [5:0]  en;
        logic [5:0]  hi;
        logic        glob;
        logic [1:0]  edg;
        logic        last;
        logic        reti;
        logic        ieip;
        logic        x_call;
        logic [15:0] x_vec;
        logic [5:0]  x_clr;
        logic [1:0]  x_isv;
    } row_t;

    localparam int NROWS = 15;
    localparam row_t ROWS [NROWS] = '{
        '{6'h01, 6'h3F, 6'h00, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0003, 6'h01, 2'b01}, // R7 R8 ext0 edge
        '{6'h01, 6'h3F, 6'h00, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0003, 6'h00, 2'b01}, // R8 ext0 level
        '{6'h02, 6'h3F, 6'h00, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 16'h000B, 6'h02, 2'b01}, // R7 timer0
        '{6'h04, 6'h3F, 6'h00, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0013, 6'h04, 2'b01}, // R7 ext1
        '{6'h08, 6'h3F, 6'h00, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 16'h001B, 6'h08, 2'b01}, // R7 timer1
        '{6'h10, 6'h3F, 6'h00, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0023, 6'h00, 2'b01}, // R8 serial
        '{6'h20, 6'h3F, 6'h00, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 16'h002B, 6'h00, 2'b01}, // R8 timer2
        '{6'h3F, 6'h3F, 6'h00, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0003, 6'h01, 2'b01}, // R6 tie
        '{6'h11, 6'h3F, 6'h10, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0023, 6'h00, 2'b10}, // R6 level
        '{6'h01, 6'h3F, 6'h00, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 6'h00, 2'b00}, // R2 global
        '{6'h01, 6'h3E, 6'h00, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 6'h00, 2'b00}, // R2 source
        '{6'h01, 6'h3F, 6'h00, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 6'h00, 2'b00}, // R3
        '{6'h01, 6'h3F, 6'h00, 1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 6'h00, 2'b00}, // R4 reti
        '{6'h01, 6'h3F, 6'h00, 1'b1, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 6'h00, 2'b00}, // R4 ie/ip
        '{6'h28, 6'h3F, 6'h28, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 16'h001B, 6'h08, 2'b10}  // R6 hi tie
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_flags = '0; src_en = 6'h3F; src_hi_pri = '0; glob_en = 1'b1;
        ext_edge = 2'b11; instr_last = 1'b1; instr_reti = 1'b0; instr_ie_ip = 1'b0;
        reti_done = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // raise flags at a negedge, sample the call cycle after two edges, then drop them
    task automatic poll_once(input logic [5:0] f, input logic [5:0] hi,
                             output logic c, output logic [15:0] v, output logic [5:0] cl);
        req_flags = f; src_hi_pri = hi;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        c = call_req; v = call_vector; cl = flag_clr;
        req_flags = '0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic pulse_reti();
        reti_done = 1'b1;
        @(posedge clk); @(negedge clk);
        reti_done = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic        c;
        logic [15:0] v;
        logic [5:0]  cl;
        int          seen;

        // R11 reset state
        @(negedge clk);
        chk("R11 call_req", 32'(call_req), 0);
        chk("R11 vector", 32'(call_vector), 0);
        chk("R11 flag_clr", 32'(flag_clr), 0);
        chk("R11 in_service", 32'(in_service), 0);

        // table walk: R1 timing is implied by sampling two edges after the flag
        for (int i = 0; i < NROWS; i++) begin
            do_reset();
            req_flags = ROWS[i].flags; src_en = ROWS[i].en; src_hi_pri = ROWS[i].hi;
            glob_en = ROWS[i].glob; ext_edge = ROWS[i].edg; instr_last = ROWS[i].last;
            instr_reti = ROWS[i].reti; instr_ie_ip = ROWS[i].ieip;
            @(posedge clk); @(negedge clk);
            chk("R1 no call before poll", 32'(call_req), 0);
            @(posedge clk); @(negedge clk);
            chk($sformatf("R1 call row %0d", i), 32'(call_req), 32'(ROWS[i].x_call));
            chk($sformatf("R7 vector row %0d", i), 32'(call_vector), 32'(ROWS[i].x_vec));
            chk($sformatf("R8 clear row %0d", i), 32'(flag_clr), 32'(ROWS[i].x_clr));
            req_flags = '0; instr_last = 1'b0; instr_reti = 1'b0; instr_ie_ip = 1'b0;
            @(posedge clk); @(negedge clk);
            chk("R1 single-cycle call", 32'(call_req), 0);
            chk($sformatf("R9 in_service row %0d", i), 32'(in_service), 32'(ROWS[i].x_isv));
        end

        // R5 equal level blocked, R6 high preempts, R9 nested clear order
        do_reset();
        poll_once(6'h01, 6'h00, c, v, cl);
        chk("R9 low set", 32'(in_service), 32'h1);
        poll_once(6'h02, 6'h00, c, v, cl);
        chk("R5 equal level blocked", 32'(c), 0);
        poll_once(6'h10, 6'h10, c, v, cl);
        chk("R6 high preempts low", 32'(c), 1);
        chk("R7 serial vector nested", 32'(v), 32'h0023);
        chk("R9 both set", 32'(in_service), 32'h3);
        poll_once(6'h02, 6'h02, c, v, cl);
        chk("R5 high blocked by high", 32'(c), 0);
        pulse_reti();
        chk("R9 reti clears high first", 32'(in_service), 32'h1);
        pulse_reti();
        chk("R9 reti clears low", 32'(in_service), 32'h0);
        poll_once(6'h02, 6'h00, c, v, cl);
        chk("R5 unblocked after returns", 32'(c), 1);

        // R10 denied request is forgotten after its flag drops
        do_reset();
        instr_last = 1'b0;
        req_flags = 6'h04;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        req_flags = '0;
        @(posedge clk); @(negedge clk);
        instr_last = 1'b1;
        seen = 0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); @(negedge clk);
            if (call_req) seen++;
        end
        chk("R10 no service after flag dropped", 32'(seen), 0);
        chk("R10 in_service idle", 32'(in_service), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule